// File: doc/BRIEF.md
# NAND Read Prefetch FIFO Engine

This engine streams bytes from a NAND flash byte port into a system DMA through a small internal FIFO. Software writes a fill size and a block count, then raises the enable. The engine pulls bytes from the flash side until the FIFO holds the fill size. It then drops an active-low DMA request and waits while the DMA drains the FIFO. When the FIFO is empty, the request goes high again and the next fill starts.

Filling and draining never overlap. Each completed fill uses up one unit of the block count. The fill during which the count reaches zero is the last one. After its drain, the engine raises a done flag and stays quiet until software clears the enable. Clearing the enable aborts any run at once, empties the FIFO and returns the engine to idle.

Top module: `nand_prefetch_engine`

## Requirements
- R1: After reset, `dma_req_n` is high, `fl_rd_req` is low and `done` is low.
- R2: `fl_rd_req` is high only during a fill phase, only while `fl_ready` is 1 (1 = ready, 0 = busy), and never while `dma_req_n` is low. A byte is taken on every rising clock edge where both `fl_rd_req` and `fl_rd_ack` are high.
- R3: `dma_req_n` goes low in the cycle after the FIFO reaches the fill target. It stays low until the DMA has read exactly that many bytes, then returns high.
- R4: `dma_rd_data` always shows the oldest byte in the FIFO. Each edge where `dma_rd` is high while `dma_req_n` is low removes one byte. Bytes reach the DMA in the order they were taken from flash.
- R5: `dma_rd` has no effect while `dma_req_n` is high.
- R6: The block count is captured when the enable rises. Each completed fill decrements it. The number of request windows in a run equals the block count, and no flash read happens after the last window.
- R7: `done` is set in the cycle after the last byte of the final window is read. It stays set, with no flash reads and the request high, until the enable is cleared.
- R8: A block count of 0 at enable sets `done` on the next edge, with no flash read and no request.
- R9: A fill size of 0, or a fill size larger than the FIFO depth (16 by default), is treated as the FIFO depth. The fill size is captured when the enable rises.
- R10: When `cfg_enable` is low at a clock edge, the engine is idle after that edge: FIFO emptied, `dma_req_n` high, `done` low. A later enable starts a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Prefetch enable; low forces idle |
| cfg_fill_size | input | $clog2(DEPTH+1) | Bytes per fill |
| cfg_block_count | input | CNT_W | Number of fills in a run |
| fl_ready | input | 1 | Flash ready (1) / busy (0) |
| fl_rd_req | output | 1 | Flash byte read request |
| fl_rd_ack | input | 1 | Flash accepts the read this cycle |
| fl_rd_data | input | DATA_W | Flash byte, valid with the acknowledge |
| dma_req_n | output | 1 | Active-low DMA request |
| dma_rd | input | 1 | DMA pops one byte |
| dma_rd_data | output | DATA_W | Oldest FIFO byte |
| done | output | 1 | Run finished |

## Verification
The bench drives random busy and acknowledge patterns, and keeps the DMA read strobe active during fills. A design that took reads while busy, or popped outside a window, would lose or reorder bytes in the scoreboard. Window lengths are measured for an odd fill size, for a fill size of 0 and for an oversize fill size. An off-by-one in the fill target or a missing clamp shows up as a wrong window length. The number of windows is counted against the block count, including a count of 0. A counter that decremented at the wrong point would give one window too many or too few. Dropping the enable in the middle of a window, then starting a short new run, checks that stale FIFO contents never reach the DMA.

// File: rtl/nand_pf_pkg.sv
package nand_pf_pkg;
  typedef enum logic [1:0] {
    PF_IDLE  = 2'd0,
    PF_FILL  = 2'd1,
    PF_DRAIN = 2'd2,
    PF_DONE  = 2'd3
  } pf_state_t;
endpackage

// File: rtl/nand_pf_fifo.sv
module nand_pf_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          push,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          pop,
  output logic [DATA_W-1:0]             rdata,
  output logic [$clog2(DEPTH+1)-1:0]    count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_nxt, rd_ptr_nxt;
  logic [CW-1:0] count_nxt;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    count_nxt  = count;
    if (clr) begin
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
      count_nxt  = '0;
    end else begin
      if (push) wr_ptr_nxt = ptr_inc(wr_ptr);
      if (pop)  rd_ptr_nxt = ptr_inc(rd_ptr);
      case ({push, pop})
        2'b10:   count_nxt = count + 1'b1;
        2'b01:   count_nxt = count - 1'b1;
        default: count_nxt = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/nand_pf_blkcnt.sv
module nand_pf_blkcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] value, value_nxt;

  always_comb begin
    value_nxt = value;
    if (load)                  value_nxt = load_val;
    else if (dec && value != 0) value_nxt = value - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= value_nxt;
  end

  assign zero = (value == '0);
endmodule

// File: rtl/nand_pf_ctrl.sv
module nand_pf_ctrl
  import nand_pf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic [$clog2(DEPTH+1)-1:0]  fill_size,
  input  logic                        blk_cfg_zero,
  input  logic                        blk_zero,
  input  logic                        fl_ready,
  input  logic                        fl_ack,
  input  logic                        dma_rd,
  input  logic [$clog2(DEPTH+1)-1:0]  fifo_cnt,
  output pf_state_t                   state,
  output logic [$clog2(DEPTH+1)-1:0]  tgt,
  output logic                        fl_req,
  output logic                        push,
  output logic                        pop,
  output logic                        fifo_clr,
  output logic                        blk_load,
  output logic                        blk_dec
);
  localparam int CW = $clog2(DEPTH + 1);

  pf_state_t     state_nxt;
  logic [CW-1:0] tgt_nxt;
  logic [CW-1:0] tgt_clamped;
  logic [CW:0]   cnt_plus1;

  assign tgt_clamped = (fill_size == '0 || fill_size > CW'(DEPTH)) ? CW'(DEPTH) : fill_size;
  assign cnt_plus1   = {1'b0, fifo_cnt} + 1'b1;

  assign fl_req   = (state == PF_FILL) && fl_ready && (fifo_cnt < tgt);
  assign push     = fl_req && fl_ack;
  assign pop      = (state == PF_DRAIN) && dma_rd && (fifo_cnt != '0);
  assign fifo_clr = !enable;

  always_comb begin
    state_nxt = state;
    tgt_nxt   = tgt;
    blk_load  = 1'b0;
    blk_dec   = 1'b0;
    if (!enable) begin
      state_nxt = PF_IDLE;
    end else begin
      case (state)
        PF_IDLE: begin
          blk_load  = 1'b1;
          tgt_nxt   = tgt_clamped;
          state_nxt = blk_cfg_zero ? PF_DONE : PF_FILL;
        end
        PF_FILL: begin
          if (push && cnt_plus1 == {1'b0, tgt}) begin
            blk_dec   = 1'b1;
            state_nxt = PF_DRAIN;
          end
        end
        PF_DRAIN: begin
          if (pop && fifo_cnt == CW'(1))
            state_nxt = blk_zero ? PF_DONE : PF_FILL;
        end
        default: state_nxt = PF_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PF_IDLE;
      tgt   <= '0;
    end else begin
      state <= state_nxt;
      tgt   <= tgt_nxt;
    end
  end
endmodule

// File: rtl/nand_prefetch_engine.sv
module nand_prefetch_engine
  import nand_pf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_enable,
  input  logic [$clog2(DEPTH+1)-1:0]  cfg_fill_size,
  input  logic [CNT_W-1:0]            cfg_block_count,
  input  logic                        fl_ready,
  output logic                        fl_rd_req,
  input  logic                        fl_rd_ack,
  input  logic [DATA_W-1:0]           fl_rd_data,
  output logic                        dma_req_n,
  input  logic                        dma_rd,
  output logic [DATA_W-1:0]           dma_rd_data,
  output logic                        done
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          rst_meta, rst_core_n;
  pf_state_t     state;
  logic [CW-1:0] fifo_cnt, fill_tgt;
  logic          push, pop, fifo_clr, blk_load, blk_dec, blk_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  nand_pf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .enable       (cfg_enable),
    .fill_size    (cfg_fill_size),
    .blk_cfg_zero (cfg_block_count == '0),
    .blk_zero     (blk_zero),
    .fl_ready     (fl_ready),
    .fl_ack       (fl_rd_ack),
    .dma_rd       (dma_rd),
    .fifo_cnt     (fifo_cnt),
    .state        (state),
    .tgt          (fill_tgt),
    .fl_req       (fl_rd_req),
    .push         (push),
    .pop          (pop),
    .fifo_clr     (fifo_clr),
    .blk_load     (blk_load),
    .blk_dec      (blk_dec)
  );

  nand_pf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (fifo_clr),
    .push  (push),
    .wdata (fl_rd_data),
    .pop   (pop),
    .rdata (dma_rd_data),
    .count (fifo_cnt)
  );

  nand_pf_blkcnt #(.CNT_W(CNT_W)) u_blkcnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (blk_load),
    .load_val (cfg_block_count),
    .dec      (blk_dec),
    .zero     (blk_zero)
  );

  assign dma_req_n = (state != PF_DRAIN);
  assign done      = (state == PF_DONE);
endmodule

// File: rtl/nand_pf_checker.sv
module nand_pf_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_enable,
  input logic                       fl_ready,
  input logic                       fl_rd_req,
  input logic                       dma_req_n,
  input logic                       done,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic [$clog2(DEPTH+1)-1:0] fill_tgt
);
  assert_busy_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_ready |-> !fl_rd_req);

  assert_no_read_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req_n |-> !fl_rd_req);

  assert_req_fall_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req_n) |-> (fifo_cnt == fill_tgt));

  assert_req_rise_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req_n) |-> (fifo_cnt == '0));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!fl_rd_req && dma_req_n));

  assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH));

  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (dma_req_n && !done && fifo_cnt == '0));
endmodule

bind nand_prefetch_engine nand_pf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .cfg_enable (cfg_enable),
  .fl_ready   (fl_ready),
  .fl_rd_req  (fl_rd_req),
  .dma_req_n  (dma_req_n),
  .done       (done),
  .fifo_cnt   (fifo_cnt),
  .fill_tgt   (fill_tgt)
);

// File: tb/nand_prefetch_engine_tb.sv
module nand_prefetch_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int CW         = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_enable;
  logic [CW-1:0] cfg_fill_size;
  logic [7:0]    cfg_block_count;
  logic          fl_ready, fl_rd_req, fl_rd_ack;
  logic [7:0]    fl_rd_data;
  logic          dma_req_n, dma_rd, done;
  logic [7:0]    dma_rd_data;

  int total = 0;
  int bad   = 0;
  int mode  = 0;
  int chk_win = 0;
  int win_w = 0;
  int win_bytes = 0;
  int windows = 0;
  int win_starts = 0;
  int xfers = 0;
  logic prev_req_n = 1'b1;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] sb_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_prefetch_engine u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_enable      (cfg_enable),
    .cfg_fill_size   (cfg_fill_size),
    .cfg_block_count (cfg_block_count),
    .fl_ready        (fl_ready),
    .fl_rd_req       (fl_rd_req),
    .fl_rd_ack       (fl_rd_ack),
    .fl_rd_data      (fl_rd_data),
    .dma_req_n       (dma_req_n),
    .dma_rd          (dma_rd),
    .dma_rd_data     (dma_rd_data),
    .done            (done)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Flash driver plus DMA monitor: drives at negedge, samples before the next posedge.
  initial begin
    fl_ready = 1'b0; fl_rd_ack = 1'b0; dma_rd = 1'b0; fl_rd_data = 8'h00;
    @(posedge rst_n);
    forever begin
      logic xfer;
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (mode == 1) begin
        fl_ready  = lfsr[0] | lfsr[5];
        fl_rd_ack = lfsr[1] | lfsr[7];
        dma_rd    = lfsr[3];
      end else begin
        fl_ready = 1'b1; fl_rd_ack = 1'b1; dma_rd = 1'b1;
      end
      #1;
      if (!fl_ready) check(!fl_rd_req, "R2 read while busy", fl_rd_req, 0);
      if (!dma_req_n) check(!fl_rd_req, "R2 read inside window", fl_rd_req, 0);
      if (prev_req_n && !dma_req_n) begin
        win_bytes = 0;
        win_starts++;
      end
      if (!prev_req_n && dma_req_n) begin
        windows++;
        if (chk_win != 0) check(win_bytes == win_w, "R3 window length", win_bytes, win_w);
      end
      prev_req_n = dma_req_n;
      if (!dma_req_n && dma_rd) begin
        if (sb_q.size() == 0) check(1'b0, "R4 pop with empty scoreboard", 0, 1);
        else begin
          check(dma_rd_data == sb_q[0], "R4 data order", dma_rd_data, sb_q[0]);
          void'(sb_q.pop_front());
        end
        win_bytes++;
      end
      xfer = fl_rd_req && fl_rd_ack;
      @(posedge clk);
      #1;
      if (xfer) begin
        sb_q.push_back(fl_rd_data);
        fl_rd_data = fl_rd_data + 8'd1;
        xfers++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic do_run(input int n, input int f, input int w, input int m);
    int waited;
    mode = m;
    cfg_block_count = 8'(n);
    cfg_fill_size   = CW'(f);
    chk_win = 1; win_w = w; windows = 0; xfers = 0;
    @(negedge clk);
    cfg_enable = 1'b1;
    waited = 0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    #2;
    check(done == 1'b1, "R7 done after run", done, 1);
    check(windows == n, "R6 window count", windows, n);
    check(xfers == n * w, "R6 total flash reads", xfers, n * w);
    check(sb_q.size() == 0, "R4 all bytes delivered", sb_q.size(), 0);
    if (n == 0) check(waited <= 2, "R8 immediate done", waited, 1);
    repeat (4) begin
      @(negedge clk); #2;
      check(done && dma_req_n && !fl_rd_req, "R7 done held quiet", done, 1);
    end
    cfg_enable = 1'b0;
    @(negedge clk); #2;
    check(!done && dma_req_n, "R10 done cleared on disable", done, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_enable = 1'b0;
    cfg_fill_size = '0;
    cfg_block_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check(dma_req_n == 1'b1, "R1 reset request", dma_req_n, 1);
    check(fl_rd_req == 1'b0, "R1 reset flash read", fl_rd_req, 0);
    check(done == 1'b0, "R1 reset done", done, 0);

    do_run(3, 4, 4, 0);    // R5: dma_rd held high during fills
    do_run(4, 7, 7, 1);    // R2: busy and ack stalls
    do_run(2, 0, 16, 0);   // R9: zero fill size
    do_run(2, 20, 16, 1);  // R9: oversize fill size
    do_run(0, 4, 4, 0);    // R8: zero block count

    // R10: abort in the second window, then a fresh short run
    mode = 0; chk_win = 0; win_starts = 0;
    cfg_block_count = 8'd5;
    cfg_fill_size = CW'(3);
    @(negedge clk);
    cfg_enable = 1'b1;
    while (win_starts < 2) @(negedge clk);
    cfg_enable = 1'b0;
    @(negedge clk); #2;
    check(dma_req_n && !fl_rd_req && !done, "R10 idle after abort", dma_req_n, 1);
    @(negedge clk); #2;
    sb_q.delete();
    do_run(1, 2, 2, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule